// File: doc/BRIEF.md
# Hotplug Event Status Register Bank

This block keeps slot insertion and removal events for a set of buses. Each bus has 32 slots and three 32-bit masks: pending insertions, pending removals and removable slots. Hardware reports events one at a time. Each event carries a bus index, a slot number and a kind. Software selects a bus through a select register. It then reads that bus's masks through a small word-addressed window and acknowledges a removal by writing an eject mask. An accepted eject produces a one-cycle, one-hot strobe that tells the slot to power off, together with the bus index it applies to.

A strap selects legacy mode. In legacy mode the window is narrower, so the select register cannot be reached. Reading the insertion mask in legacy mode also leaves the mask intact. In normal mode that read clears the mask. A warm reset request runs a flush sequence. The flush walks the buses in ascending order and ejects each pending removal, lowest slot first and one per cycle. After a bus has no removals left, the flush loads that bus's removable mask from the complement of the non-removable qualifier inputs. Power-on reset clears all state and then runs the same flush.

Top module: `hp_status_bank`

## Requirements
- R1: Register offsets: 0x00 insertion mask, 0x04 removal mask, 0x08 eject (always reads 0), 0x0C removable mask, 0x10 bus select (reads back the written value). Read data appears with `rd_valid` in the cycle after the request.
- R2: `ev_kind` encoding is 0 cold, 1 plug, 2 unplug, 3 none. A plug event sets the slot bit in the insertion mask of `ev_bus`. An unplug event sets the slot bit in the removal mask. A cold event sets nothing. An event whose bus index is not below NUM_BUS is ignored.
- R3: In normal mode, a valid read of offset 0x00 returns the insertion mask and clears it.
- R4: In legacy mode, a read of offset 0x00 leaves the insertion mask unchanged.
- R5: A write to 0x08 acts only on the lowest set bit of the write data. It clears that slot in both the insertion and removal masks of the selected bus. In the next cycle `eject_strobe` carries that one-hot bit for one cycle and `eject_bus` carries the bus index. Write data of 0 does nothing.
- R6: When the select value is not below NUM_BUS, every read returns 0 and eject writes are dropped.
- R7: An access with `req_full` low is ignored and reads 0.
- R8: The decoded window is 0x00–0x13 in normal mode and 0x00–0x0E in legacy mode. Offsets outside the window or not a multiple of 4 read 0 and ignore writes, so the select register is unreachable in legacy mode.
- R9: A hardware event in the same cycle as a clearing read or an eject of the same bit wins, and the bit stays set.
- R10: After a `warm_rst` pulse, pending removals are ejected one per cycle, in ascending bus order and then lowest slot first. Each bus's removable mask then becomes the complement of its `fixed_mask` field.
- R11: While the flush runs, reads return 0 and writes are ignored. Events are still recorded.
- R12: After power-on reset, the select value and the insertion and removal masks are 0, and each removable mask equals the complement of its `fixed_mask` field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | One-cycle request that starts the flush sequence |
| legacy_mode | input | 1 | Strap: narrow window, insertion mask not cleared on read |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | 1 = full 32-bit access |
| req_addr | input | 5 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| ev_valid | input | 1 | Hardware event strobe |
| ev_bus | input | BUS_W | Bus index of the event |
| ev_slot | input | 5 | Slot number of the event |
| ev_kind | input | 2 | Event kind (R2 encoding) |
| fixed_mask | input | NUM_BUS*32 | Per-bus non-removable slot flags, bus 0 in the low word |
| eject_strobe | output | 32 | One-hot eject pulse |
| eject_bus | output | BUS_W | Bus index for the eject pulse |

## Verification
A corrupted mask bit is visible on the next read of that bus's register. A missed clear after an insertion read shows up on the following read as a stale bit. A wrong lowest-bit pick appears as a wrong one-hot value on `eject_strobe` in the cycle after the eject write. Flush ordering faults show up as a strobe sequence in the wrong order within a few cycles of `warm_rst`. A removable mask that was loaded wrongly reads back incorrectly as soon as the flush finishes.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int SLOTS  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        EV_COLD   = 2'd0,
        EV_PLUG   = 2'd1,
        EV_UNPLUG = 2'd2,
        EV_NONE   = 2'd3
    } ev_kind_e;

    typedef enum logic [2:0] {
        REG_INS,
        REG_REM,
        REG_EJECT,
        REG_RMV,
        REG_SEL,
        REG_NONE
    } reg_e;
endpackage

// File: rtl/hp_addr_decode.sv
module hp_addr_decode
    import hp_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              legacy,
    output reg_e              reg_sel
);
    localparam logic [ADDR_W-1:0] WIN_NORMAL = ADDR_W'(20);
    localparam logic [ADDR_W-1:0] WIN_LEGACY = ADDR_W'(15);

    logic [ADDR_W-1:0] win;

    always_comb begin
        win = legacy ? WIN_LEGACY : WIN_NORMAL;
        reg_sel = REG_NONE;
        if (addr < win && addr[1:0] == 2'b00) begin
            unique case (addr[4:2])
                3'd0:    reg_sel = REG_INS;
                3'd1:    reg_sel = REG_REM;
                3'd2:    reg_sel = REG_EJECT;
                3'd3:    reg_sel = REG_RMV;
                3'd4:    reg_sel = REG_SEL;
                default: reg_sel = REG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] onehot,
    output logic         any
);
    assign onehot = vec & (~vec + W'(1));
    assign any    = |vec;
endmodule

// File: rtl/hp_status_bank.sv
module hp_status_bank
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4,
    localparam int BUS_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       warm_rst,
    input  logic                       legacy_mode,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic                       req_full,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       rd_valid,
    output logic [DATA_W-1:0]          rd_data,
    input  logic                       ev_valid,
    input  logic [BUS_W-1:0]           ev_bus,
    input  logic [4:0]                 ev_slot,
    input  logic [1:0]                 ev_kind,
    input  logic [NUM_BUS*SLOTS-1:0]   fixed_mask,
    output logic [SLOTS-1:0]           eject_strobe,
    output logic [BUS_W-1:0]           eject_bus
);
    localparam logic [BUS_W-1:0] LAST_BUS = BUS_W'(NUM_BUS - 1);
    localparam logic [BUS_W:0]   NB_EXT   = (BUS_W + 1)'(NUM_BUS);

    typedef struct packed {
        logic [NUM_BUS-1:0][SLOTS-1:0] ins;
        logic [NUM_BUS-1:0][SLOTS-1:0] rem;
        logic [NUM_BUS-1:0][SLOTS-1:0] rmv;
        logic [DATA_W-1:0]             sel;
        logic                          flushing;
        logic [BUS_W-1:0]              fbus;
        logic                          rvalid;
        logic [DATA_W-1:0]             rdata;
        logic [SLOTS-1:0]              ej;
        logic [BUS_W-1:0]              ejbus;
    } state_t;

    state_t q, d;

    logic [NUM_BUS-1:0][SLOTS-1:0] fixed_arr;
    reg_e                          dec_reg;
    logic [SLOTS-1:0]              wr_oh, fl_oh, ev_oh;
    logic                          wr_any, fl_any;
    logic                          sel_ok, ev_ok;
    logic [BUS_W-1:0]              sel_idx;

    assign fixed_arr = fixed_mask;
    assign sel_ok    = (q.sel < DATA_W'(NUM_BUS));
    assign sel_idx   = q.sel[BUS_W-1:0];
    assign ev_ok     = ev_valid && ({1'b0, ev_bus} < NB_EXT);
    assign ev_oh     = SLOTS'(1) << ev_slot;

    hp_addr_decode u_dec (
        .addr    (req_addr),
        .legacy  (legacy_mode),
        .reg_sel (dec_reg)
    );

    hp_lowbit #(.W(SLOTS)) u_wr_low (
        .vec    (req_wdata),
        .onehot (wr_oh),
        .any    (wr_any)
    );

    hp_lowbit #(.W(SLOTS)) u_fl_low (
        .vec    (q.rem[q.fbus]),
        .onehot (fl_oh),
        .any    (fl_any)
    );

    always_comb begin
        d       = q;
        d.rvalid = req_valid && !req_write;
        d.rdata  = '0;
        d.ej     = '0;
        d.ejbus  = '0;

        if (q.flushing) begin
            // pending removals first, then the removable mask, bus by bus
            if (fl_any) begin
                d.ins[q.fbus] = q.ins[q.fbus] & ~fl_oh;
                d.rem[q.fbus] = q.rem[q.fbus] & ~fl_oh;
                d.ej          = fl_oh;
                d.ejbus       = q.fbus;
            end else begin
                d.rmv[q.fbus] = ~fixed_arr[q.fbus];
                if (q.fbus == LAST_BUS) begin
                    d.flushing = 1'b0;
                end else begin
                    d.fbus = q.fbus + BUS_W'(1);
                end
            end
        end else if (req_valid && req_full && !warm_rst) begin
            if (req_write) begin
                unique case (dec_reg)
                    REG_EJECT: begin
                        if (sel_ok && wr_any) begin
                            d.ins[sel_idx] = q.ins[sel_idx] & ~wr_oh;
                            d.rem[sel_idx] = q.rem[sel_idx] & ~wr_oh;
                            d.ej           = wr_oh;
                            d.ejbus        = sel_idx;
                        end
                    end
                    REG_SEL: d.sel = req_wdata;
                    default: ;
                endcase
            end else if (sel_ok) begin
                unique case (dec_reg)
                    REG_INS: begin
                        d.rdata = q.ins[sel_idx];
                        if (!legacy_mode) d.ins[sel_idx] = '0;
                    end
                    REG_REM: d.rdata = q.rem[sel_idx];
                    REG_RMV: d.rdata = q.rmv[sel_idx];
                    REG_SEL: d.rdata = q.sel;
                    default: d.rdata = '0;
                endcase
            end
        end

        // events are applied last so they win over same-cycle clears
        if (ev_ok) begin
            if (ev_kind == EV_PLUG)   d.ins[ev_bus] = d.ins[ev_bus] | ev_oh;
            if (ev_kind == EV_UNPLUG) d.rem[ev_bus] = d.rem[ev_bus] | ev_oh;
        end

        if (warm_rst) begin
            d.flushing = 1'b1;
            d.fbus     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.flushing <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_valid     = q.rvalid;
    assign rd_data      = q.rdata;
    assign eject_strobe = q.ej;
    assign eject_bus    = q.ejbus;

    a_r5_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eject_strobe));

    a_r5_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        (eject_strobe != '0) |-> $past(q.flushing || (req_valid && req_write)));

    a_r1_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    a_r1_eject_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADDR_W'(8)) |=> (rd_data == '0));

    a_r8_legacy_sel_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_mode && req_valid && !req_write && req_addr == ADDR_W'(16)) |=> (rd_data == '0));

    a_r11_flush_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flushing && req_valid && !req_write) |=> (rd_data == '0));

    a_r10_rmv_only_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !q.flushing |=> $stable(q.rmv));
endmodule

// File: tb/hp_status_bank_bench.sv
module hp_status_bank_bench;
    localparam int NB = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        legacy_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_full = 1'b1;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_bus = '0;
    logic [4:0]  ev_slot = '0;
    logic [1:0]  ev_kind = 2'd3;
    logic [NB*32-1:0] fixed_mask;
    logic [31:0] eject_strobe;
    logic [1:0]  eject_bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] rd, ej;
    logic [1:0]  eb;
    logic [31:0] m_ins [NB];
    logic [31:0] m_rem [NB];

    always #2 clk = ~clk;

    hp_status_bank #(.NUM_BUS(NB)) u_hp_status_bank (
        .clk, .rst_n, .warm_rst, .legacy_mode,
        .req_valid, .req_write, .req_full, .req_addr, .req_wdata,
        .rd_valid, .rd_data,
        .ev_valid, .ev_bus, .ev_slot, .ev_kind,
        .fixed_mask, .eject_strobe, .eject_bus
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input bit full, input logic [4:0] a, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_full = full; req_addr = a; req_wdata = wd;
        @(posedge clk); #1;
        rd = rd_data; ej = eject_strobe; eb = eject_bus;
        req_valid = 1'b0; req_full = 1'b1;
    endtask

    task automatic evt(input logic [1:0] b, input logic [4:0] s, input logic [1:0] k);
        @(negedge clk);
        ev_valid = 1'b1; ev_bus = b; ev_slot = s; ev_kind = k;
        @(posedge clk); #1;
        ev_valid = 1'b0; ev_kind = 2'd3;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        fixed_mask = {32'h8000_0001, 32'h0000_0000, 32'h0000_00F0};
        for (int i = 0; i < NB; i++) begin m_ins[i] = '0; m_rem[i] = '0; end
        wait_cyc(3);
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(8);

        // R12 power-on state
        acc(0, 1, 5'h10, 0); chk("R12 sel after reset", rd, 32'h0);
        chk("R1 rd_valid on read", {31'b0, rd_valid}, 32'h1);
        for (int b = 0; b < NB; b++) begin
            acc(1, 1, 5'h10, b);
            acc(0, 1, 5'h00, 0); chk("R12 ins zero", rd, 32'h0);
            acc(0, 1, 5'h04, 0); chk("R12 rem zero", rd, 32'h0);
            acc(0, 1, 5'h0C, 0); chk("R12 rmv loaded", rd, ~fixed_mask[b*32 +: 32]);
        end
        acc(1, 1, 5'h10, 1);
        acc(0, 1, 5'h10, 0); chk("R1 sel readback", rd, 32'h1);
        acc(0, 1, 5'h08, 0); chk("R1 eject reads zero", rd, 32'h0);

        // R2 / R3 sweep: plug every slot, read returns it then clears
        for (int b = 0; b < NB; b++) begin
            acc(1, 1, 5'h10, b);
            for (int s = 0; s < 32; s++) begin
                evt(2'(b), 5'(s), 2'd1);
                acc(0, 1, 5'h00, 0); chk("R2 plug sets bit", rd, 32'h1 << s);
                acc(0, 1, 5'h00, 0); chk("R3 read clears ins", rd, 32'h0);
            end
        end

        // R2 / R5 sweep: unplug accumulates, eject lowest bit one at a time
        for (int b = 0; b < NB; b++) begin
            logic [31:0] m;
            m = '0;
            acc(1, 1, 5'h10, b);
            for (int s = 0; s < 32; s++) begin
                evt(2'(b), 5'(s), 2'd2);
                m |= 32'h1 << s;
                acc(0, 1, 5'h04, 0); chk("R2 unplug accumulates", rd, m);
            end
            while (m != 0) begin
                logic [31:0] low;
                low = m & (~m + 1);
                acc(1, 1, 5'h08, m);
                chk("R5 eject lowest bit", ej, low);
                chk("R5 eject bus", {30'b0, eb}, b);
                wait_cyc(1);
                chk("R5 strobe single cycle", eject_strobe, 32'h0);
                m &= m - 1;
            end
            acc(0, 1, 5'h04, 0); chk("R5 rem empty", rd, 32'h0);
        end

        // R2 cold event and out-of-range bus ignored
        acc(1, 1, 5'h10, 0);
        evt(2'd0, 5'd0, 2'd0);
        evt(2'd3, 5'd0, 2'd1);
        evt(2'd3, 5'd1, 2'd2);
        acc(0, 1, 5'h00, 0); chk("R2 cold sets nothing", rd, 32'h0);
        acc(0, 1, 5'h04, 0); chk("R2 cold sets nothing rem", rd, 32'h0);
        acc(1, 1, 5'h08, 0); chk("R5 zero data no strobe", ej, 32'h0);

        // R4 legacy keeps ins; R8 select hidden in legacy
        legacy_mode = 1'b1;
        evt(2'd0, 5'd12, 2'd1);
        acc(0, 1, 5'h00, 0); chk("R4 legacy read", rd, 32'h1000);
        acc(0, 1, 5'h00, 0); chk("R4 legacy preserved", rd, 32'h1000);
        acc(0, 1, 5'h10, 0); chk("R8 legacy sel reads zero", rd, 32'h0);
        acc(1, 1, 5'h10, 2);
        evt(2'd0, 5'd13, 2'd1);
        acc(1, 1, 5'h08, 32'h2000); chk("R5 legacy eject strobe", ej, 32'h2000);
        acc(0, 1, 5'h00, 0); chk("R5 eject clears ins", rd, 32'h1000);
        legacy_mode = 1'b0;
        acc(0, 1, 5'h10, 0); chk("R8 legacy sel write ignored", rd, 32'h0);
        acc(0, 1, 5'h00, 0); chk("R3 normal read", rd, 32'h1000);
        acc(0, 1, 5'h00, 0); chk("R3 cleared", rd, 32'h0);

        // R7 partial accesses
        evt(2'd0, 5'd1, 2'd1);
        acc(0, 0, 5'h00, 0); chk("R7 partial read zero", rd, 32'h0);
        acc(0, 1, 5'h00, 0); chk("R7 partial read no clear", rd, 32'h2);
        acc(1, 0, 5'h10, 2);
        acc(0, 1, 5'h10, 0); chk("R7 partial write ignored", rd, 32'h0);

        // R8 window edges
        acc(0, 1, 5'h14, 0); chk("R8 beyond window", rd, 32'h0);
        acc(0, 1, 5'h02, 0); chk("R8 unaligned", rd, 32'h0);

        // R6 out-of-range select
        evt(2'd0, 5'd6, 2'd2);
        acc(1, 1, 5'h10, 3);
        acc(0, 1, 5'h04, 0); chk("R6 rem reads zero", rd, 32'h0);
        acc(0, 1, 5'h10, 0); chk("R6 sel reads zero", rd, 32'h0);
        acc(1, 1, 5'h08, 32'h40); chk("R6 eject dropped", ej, 32'h0);
        acc(1, 1, 5'h10, 32'h100);
        acc(0, 1, 5'h0C, 0); chk("R6 large sel zero", rd, 32'h0);
        acc(1, 1, 5'h10, 0);
        acc(0, 1, 5'h04, 0); chk("R6 rem untouched", rd, 32'h40);

        // R9 event beats same-cycle clear
        evt(2'd0, 5'd9, 2'd1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 5'h00;
        ev_valid = 1'b1; ev_bus = 2'd0; ev_slot = 5'd9; ev_kind = 2'd1;
        @(posedge clk); #1;
        req_valid = 1'b0; ev_valid = 1'b0; ev_kind = 2'd3;
        chk("R9 read returns old", rd_data, 32'h200);
        acc(0, 1, 5'h00, 0); chk("R9 plug survives read", rd, 32'h200);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 5'h08; req_wdata = 32'h40;
        ev_valid = 1'b1; ev_bus = 2'd0; ev_slot = 5'd6; ev_kind = 2'd2;
        @(posedge clk); #1;
        req_valid = 1'b0; ev_valid = 1'b0; ev_kind = 2'd3;
        chk("R9 eject still strobes", eject_strobe, 32'h40);
        acc(0, 1, 5'h04, 0); chk("R9 unplug survives eject", rd, 32'h40);
        acc(1, 1, 5'h08, 32'h40);

        // R10 / R11 warm reset flush
        evt(2'd1, 5'd7, 2'd2);
        evt(2'd1, 5'd3, 2'd2);
        evt(2'd1, 5'd7, 2'd1);
        evt(2'd1, 5'd20, 2'd1);
        evt(2'd2, 5'd2, 2'd2);
        acc(1, 1, 5'h10, 1);
        fixed_mask[63:32] = 32'h0000_FF00;
        @(negedge clk); warm_rst = 1'b1;
        @(posedge clk); #1; warm_rst = 1'b0;
        begin
            logic [31:0] seen_s [4];
            logic [1:0]  seen_b [4];
            int n;
            n = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (i == 0) begin req_valid = 1'b1; req_write = 1'b0; req_addr = 5'h10; end
                if (i == 1) begin req_valid = 1'b1; req_write = 1'b1; req_addr = 5'h10; req_wdata = 2; end
                if (i == 2) begin ev_valid = 1'b1; ev_bus = 2'd0; ev_slot = 5'd4; ev_kind = 2'd1; end
                @(posedge clk); #1;
                if (i == 0) chk("R11 read during flush", rd_data, 32'h0);
                req_valid = 1'b0; ev_valid = 1'b0; ev_kind = 2'd3;
                if (eject_strobe != 0 && n < 4) begin
                    seen_s[n] = eject_strobe; seen_b[n] = eject_bus;
                end
                if (eject_strobe != 0) n++;
            end
            chk("R10 eject count", n, 3);
            chk("R10 first eject", seen_s[0], 32'h8);
            chk("R10 first bus", {30'b0, seen_b[0]}, 1);
            chk("R10 second eject", seen_s[1], 32'h80);
            chk("R10 third eject", seen_s[2], 32'h4);
            chk("R10 third bus", {30'b0, seen_b[2]}, 2);
        end
        acc(0, 1, 5'h10, 0); chk("R11 write ignored in flush", rd, 32'h1);
        acc(0, 1, 5'h04, 0); chk("R10 rem emptied", rd, 32'h0);
        acc(0, 1, 5'h00, 0); chk("R10 flush clears ins of ejected", rd, 32'h0010_0000);
        acc(0, 1, 5'h0C, 0); chk("R10 rmv reloaded", rd, 32'hFFFF_00FF);
        acc(1, 1, 5'h10, 0);
        acc(0, 1, 5'h00, 0); chk("R11 event kept in flush", rd, 32'h10);
        acc(0, 1, 5'h0C, 0); chk("R10 rmv bus0", rd, 32'hFFFF_FF0F);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule